// File: doc/BRIEF.md
# Burst Address Generator

This block supplies the array address for a four-beat burst. When the controller asks for a load, the block captures a 15-bit base address and clears its beat counter. Each later cycle in which the controller asks for an advance moves the two low address bits one step through the burst. The upper bits keep their loaded value for the whole burst.

A static order input picks one of two step patterns for the low bits. Linear order counts up from the starting value and wraps modulo four. Interleaved order flips the starting bits by the beat count. After the fourth beat the low bits return to the starting value. A cycle with no advance is a wait cycle, and the address does not change. A load during a burst starts a new burst from the new base.

The block presents the full current address and the beat index. Cycle decoding and the storage array belong to the surrounding controller.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the stored base and the beat counter clear, so after that edge `addr_o` is 0 and `beat_o` is 0.
- R2: When `load_i` is high at a rising edge, after that edge `addr_o` equals the `base_addr_i` sampled at that edge and `beat_o` is 0.
- R3: Without a load, `addr_o[14:2]` keeps the loaded base's upper bits no matter how many advances or waits occur.
- R4: With `order_i` = 0 (linear), `addr_o[1:0]` equals (base bits 1:0 + `beat_o`) modulo 4. For example, a start of 01 gives 01, 10, 11, 00.
- R5: With `order_i` = 1 (interleaved), `addr_o[1:0]` equals base bits 1:0 XOR `beat_o`. For example, a start of 10 gives 10, 11, 00, 01.
- R6: When `adv_i` and `load_i` are both low at a rising edge, `addr_o` and `beat_o` do not change.
- R7: After four advances from a load, `addr_o` again equals the loaded base and `beat_o` is 0.
- R8: A load in the same cycle as an advance takes priority and restarts the burst at beat 0 from the new base.
- R9: Each advance without a load increments `beat_o` by one, modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Capture `base_addr_i` and restart the burst |
| adv_i | input | 1 | Step to the next beat (high = advance, low = wait) |
| order_i | input | 1 | Static burst order: 0 linear, 1 interleaved |
| base_addr_i | input | 15 | External base address |
| addr_o | output | 15 | Current array address |
| beat_o | output | 2 | Index of the current beat, 0 to 3 |

## Verification
A load or an advance takes effect on the rising edge that samples it. There is one register stage, so the new `addr_o` and `beat_o` are valid right after that edge. The order input acts combinationally on the low bits. The bench drives stimulus on the falling edge and updates its behavioural model on the rising edge. It compares every output on the following falling edge, which is half a cycle after the result is due and clear of any clock-edge race. Wrap and reset results are also checked against literal values at the same point.

// File: rtl/burst_addr_pkg.sv
// Package: shared widths and the burst-order encoding for the burst address generator.
// Assumes: a burst is 2**BURST_CNT_W beats long and the order input is static during a burst.
package burst_addr_pkg;

    localparam int unsigned BURST_CNT_W  = 2;
    localparam int unsigned BURST_ADDR_W = 15;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/bag_base_reg.sv
// Module: holds the external base address captured at the start of a burst.
// Assumes: load_i is a single-cycle request from the controller; the value is held until the next load.
module bag_base_reg #(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] base_o
);

    logic [ADDR_W-1:0] base_q;

    // Capture the base on a load; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (load_i) base_q <= base_i;
    end

    assign base_o = base_q;

    // R3: the stored base is untouched between loads.
    assert_base_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(base_q));

endmodule

// File: rtl/bag_beat_ctr.sv
// Module: beat counter for a burst; it clears on a load and wraps modulo the burst length.
// Assumes: a load has priority over an advance in the same cycle.
module bag_beat_ctr #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] beat_o
);

    logic [CNT_W-1:0] cnt_q;

    // Restart on a load, step on an advance, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= '0;
        else if (adv_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign beat_o = cnt_q;

    // R9: an advance moves the beat by exactly one, modulo the burst length.
    assert_beat_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R6: a wait cycle leaves the beat unchanged.
    assert_beat_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i) |=> $stable(cnt_q));

    // R8: a load wins over a simultaneous advance.
    assert_load_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == '0);

endmodule

// File: rtl/bag_low_map.sv
// Module: maps the base low bits and the beat index to the low address bits in either burst order.
// Assumes: purely combinational; the order select is static while a burst is running.
module bag_low_map
    import burst_addr_pkg::*;
#(
    parameter int unsigned CNT_W = 2
) (
    input  burst_order_e     order_i,
    input  logic [CNT_W-1:0] base_lo_i,
    input  logic [CNT_W-1:0] beat_i,
    output logic [CNT_W-1:0] lo_o
);

    logic [CNT_W-1:0] lin_lo;
    logic [CNT_W-1:0] ilv_lo;

    // Linear order is a wrapping sum of the start bits and the beat.
    assign lin_lo = base_lo_i + beat_i;

    // Interleaved order flips each start bit where the beat has a one.
    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
        assign ilv_lo[b] = base_lo_i[b] ^ beat_i[b];
    end

    // Pick the pattern named by the static order input.
    always_comb begin
        lo_o = (order_i == ORD_INTERLEAVE) ? ilv_lo : lin_lo;
    end

    // R4/R5: at beat 0 both orders present the start bits unchanged.
    always_comb begin
        if (beat_i == '0) assert_beat0_start_R4: assert (lo_o == base_lo_i);
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Module: top of the burst address generator. It joins the base register, the beat counter and the low-bit mapper.
// Assumes: the controller issues load_i and adv_i as synchronous strobes; order_i changes only between bursts.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int unsigned ADDR_W = BURST_ADDR_W,
    parameter int unsigned CNT_W  = BURST_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  beat_o
);

    localparam int unsigned HI_W = ADDR_W - CNT_W;

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  beat_q;
    logic [CNT_W-1:0]  lo_bits;
    burst_order_e      order_sel;

    // Convert the static order pin to the shared enum.
    always_comb begin
        order_sel = burst_order_e'(order_i);
    end

    bag_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .base_i (base_addr_i),
        .base_o (base_q)
    );

    bag_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .adv_i  (adv_i),
        .beat_o (beat_q)
    );

    bag_low_map #(.CNT_W(CNT_W)) u_map (
        .order_i   (order_sel),
        .base_lo_i (base_q[CNT_W-1:0]),
        .beat_i    (beat_q),
        .lo_o      (lo_bits)
    );

    // Assemble the array address from the held upper bits and the generated low bits.
    assign addr_o = {base_q[ADDR_W-1:CNT_W], lo_bits};
    assign beat_o = beat_q;

    // R1: the first cycle after reset presents address zero at beat zero.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (addr_o == '0 && beat_o == '0));

    // R2: a load presents the sampled base address at beat zero.
    assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(base_addr_i) && beat_o == '0));

    // R3: the upper address bits hold while no load occurs.
    assert_hi_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_o[ADDR_W-1:ADDR_W-HI_W]));

    // R4: in linear order an advance raises the low bits by one.
    assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && order_i == 1'b0) |=>
            (!$stable(order_i) || addr_o[CNT_W-1:0] == CNT_W'($past(addr_o[CNT_W-1:0]) + 1'b1)));

    // R5: in interleaved order an advance flips exactly the bits that change in the beat index.
    assert_ilv_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && order_i == 1'b1) |=>
            (!$stable(order_i) ||
             (addr_o[CNT_W-1:0] ^ $past(addr_o[CNT_W-1:0])) == (beat_o ^ $past(beat_o))));

    // R6: a wait cycle holds the whole address.
    assert_addr_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i && $stable(order_i)) |=> $stable(addr_o));

endmodule

// File: tb/tb_burst_addr_gen.sv
// Bench: behavioural reference model (integers), compared on every falling edge.
module tb_burst_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic        adv_i = 1'b0;
    logic        order_i = 1'b0;
    logic [14:0] base_addr_i = '0;
    logic [14:0] addr_o;
    logic [1:0]  beat_o;

    int n_checks = 0;
    int n_fail = 0;
    int ref_base = 0;
    int ref_cnt = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    burst_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
        .order_i(order_i), .base_addr_i(base_addr_i),
        .addr_o(addr_o), .beat_o(beat_o)
    );

    always #2 clk = ~clk;

    // Reference model: updated on the same edge the design samples.
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_base = 0;
            ref_cnt = 0;
        end else if (load_i) begin
            ref_base = int'(base_addr_i);
            ref_cnt = 0;
        end else if (adv_i) begin
            ref_cnt = (ref_cnt + 1) % 4;
        end
    end

    function automatic int exp_addr();
        int lo;
        if (order_i) lo = (ref_base % 4) ^ ref_cnt;
        else         lo = ((ref_base % 4) + ref_cnt) % 4;
        return (ref_base / 4) * 4 + lo;
    endfunction

    task automatic chk(string req, string what, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic compare();
        chk("R3", "upper bits", int'(addr_o) / 4, exp_addr() / 4);
        chk(cur_req, "low bits", int'(addr_o) % 4, exp_addr() % 4);
        chk("R9", "beat", int'(beat_o), ref_cnt);
    endtask

    // Wait for the falling edge, compare the last result, then drive the next stimulus.
    task automatic step(bit ld, bit adv, int base, bit ord, string req);
        @(negedge clk);
        compare();
        load_i = ld;
        adv_i = adv;
        base_addr_i = 15'(base);
        order_i = ord;
        cur_req = req;
    endtask

    initial begin
        // R1: reset clears the address and the beat.
        step(0, 1, 16'h1234, 0, "R1");
        step(1, 1, 16'h5555, 0, "R1");
        @(negedge clk);
        chk("R1", "addr after reset", int'(addr_o), 0);
        chk("R1", "beat after reset", int'(beat_o), 0);
        rst_n = 1'b1;
        load_i = 1'b0;
        adv_i = 1'b0;

        // R2/R4/R7: linear burst from start 01 with wrap.
        step(1, 0, 15'h1235, 0, "R2");
        step(0, 1, 15'h7fff, 0, "R4");
        step(0, 1, 0, 0, "R4");
        step(0, 1, 0, 0, "R4");
        step(0, 1, 0, 0, "R7");
        step(0, 0, 0, 0, "R6");
        chk("R7", "addr after wrap", int'(addr_o), 15'h1235);
        chk("R7", "beat after wrap", int'(beat_o), 0);

        // R5/R6: interleaved from start 10 with wait cycles.
        step(1, 0, 15'h2aa6, 1, "R2");
        step(0, 1, 0, 1, "R5");
        step(0, 0, 15'h0001, 1, "R6");
        step(0, 0, 0, 1, "R6");
        step(0, 1, 0, 1, "R5");
        step(0, 1, 0, 1, "R5");
        step(0, 1, 0, 1, "R7");
        step(0, 0, 0, 1, "R6");
        chk("R7", "interleaved wrap", int'(addr_o), 15'h2aa6);

        // R5: interleaved from start 01.
        step(1, 0, 15'h0401, 1, "R2");
        for (int i = 0; i < 3; i++) step(0, 1, 0, 1, "R5");

        // R8: a load with an advance mid-burst restarts from the new base.
        step(1, 1, 15'h3c03, 1, "R8");
        step(0, 0, 0, 1, "R6");
        chk("R8", "restart addr", int'(addr_o), 15'h3c03);
        chk("R8", "restart beat", int'(beat_o), 0);

        // R4: linear from start 11 and 10 across all beats.
        step(1, 0, 15'h0f0b, 0, "R2");
        for (int i = 0; i < 5; i++) step(0, 1, 0, 0, "R4");
        step(1, 0, 15'h6002, 0, "R2");
        for (int i = 0; i < 4; i++) step(0, (i % 2) == 0, 0, 0, "R4");
        step(0, 0, 0, 0, "R6");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule